// File: doc/BRIEF.md
# Dual-Port Byte Mailbox with Status Signalling

This block is a register mailbox between a host port and a management-controller port. Each direction has a one-byte data register and a hardware-managed full flag. The controller fills the outbound byte and the host drains it. The host fills the inbound byte and the controller drains it. A shared status byte holds the two full flags, two sticky overrun bits and four protocol bits that only the controller can write. Each port has a single-cycle register read/write interface, an interrupt output and a classification of the byte waiting for it.

A status write does not raise an interrupt by itself. For this reason the block has a signalling helper. In one request, the helper stores new protocol bits and then, on the following clock, places the dummy byte 0xFF in the outbound register. The host's outbound-full interrupt then tells it that the status has changed. The helper refuses a request while the outbound byte is still unread.

Top module: `kcs_mailbox`

## Requirements
- R1: After reset, both data bytes and the whole status byte read as zero, both interrupts are low, both byte classifications are 0 and the signalling helper is not busy.
- R2: A controller write to address 0 stores the outbound byte and sets status bit 0. `host_irq` follows bit 0 from the next cycle. A host read of address 0 returns the stored byte on `host_rdata` one cycle after the read and clears bit 0.
- R3: A host write to address 0 stores the inbound byte and sets status bit 1. `bmc_irq` follows bit 1 from the next cycle. A controller read of address 0 returns the byte on `bmc_rdata` one cycle after the read and clears bit 1.
- R4: Status bits 7:4 are written only by a controller write to address 1 (data bits 7:4). Both ports read the full status at address 1. A host write to address 1 leaves bits 7:4 unchanged. A status write by itself raises neither interrupt.
- R5: A write to a data register whose full flag is set, with no read of that register in the same cycle, replaces the byte and sets a sticky overrun bit: bit 2 for outbound, bit 3 for inbound. Writing 1 to that bit at address 1 from either port clears it.
- R6: A signalling request with `bmc_sig_busy` low writes `bmc_sig_bits` into status bits 7:4 at that clock edge. The byte 0xFF is written to the outbound register at the next edge, which sets bit 0. `bmc_sig_busy` is high from the accepting edge until the host reads the outbound byte.
- R7: A signalling request made while `bmc_sig_busy` is high is refused and changes neither the protocol bits nor the outbound byte.
- R8: Each `*_rx_kind` output classifies the byte waiting for that port: 0 means empty, 1 means ordinary data, 2 means the receive-complete code 0x02 and 3 means the dummy code 0xFF.
- R9: A write and a read of the same data register in one cycle return the old byte to the reader, store the new byte, keep the full flag set and set no overrun bit.
- R10: When the signalling helper writes the protocol bits or the dummy byte, it overrides a direct controller write to the same register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 1 | Host register select: 0 data, 1 status |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid the cycle after `host_rd` |
| host_irq | output | 1 | Outbound byte waiting for the host |
| host_rx_kind | output | 2 | Class of the outbound byte |
| bmc_wr | input | 1 | Controller write strobe |
| bmc_rd | input | 1 | Controller read strobe |
| bmc_addr | input | 1 | Controller register select: 0 data, 1 status |
| bmc_wdata | input | 8 | Controller write data |
| bmc_rdata | output | 8 | Controller read data, valid the cycle after `bmc_rd` |
| bmc_irq | output | 1 | Inbound byte waiting for the controller |
| bmc_rx_kind | output | 2 | Class of the inbound byte |
| bmc_sig_req | input | 1 | Request: update protocol bits, then send dummy byte |
| bmc_sig_bits | input | 4 | Protocol bits for the request |
| bmc_sig_busy | output | 1 | Signalling request would be refused |

## Verification
Every register write, read, flag change and interrupt in this block takes effect at the first clock edge after the strobe. Read data, interrupts, classifications and busy are therefore due one cycle after the stimulus. The only exception is the dummy byte of a signalling request, which lands one edge later again. The bench drives strobes on the falling edge and queues each expected value with the cycle in which it is due. A monitor then compares the outputs on the falling edge of that cycle. A two-step result, such as the status update followed by the dummy byte, is therefore checked once at each of its two due cycles.

// File: rtl/kcs_mailbox_pkg.sv
package kcs_mailbox_pkg;

  localparam int BYTE_W = 8;
  localparam int SW_W   = 4;

  localparam logic [BYTE_W-1:0] CODE_RX_DONE = 8'h02;
  localparam logic [BYTE_W-1:0] CODE_DUMMY   = 8'hFF;

  // Status byte: protocol bits on top, then sticky overruns, then full flags.
  typedef struct packed {
    logic [SW_W-1:0] sw;
    logic            iovr;
    logic            oovr;
    logic            ibf;
    logic            obf;
  } status_t;

  localparam int ST_OOVR = 2;
  localparam int ST_IOVR = 3;

  typedef enum logic [1:0] {
    RX_EMPTY = 2'd0,
    RX_DATA  = 2'd1,
    RX_DONE  = 2'd2,
    RX_DUMMY = 2'd3
  } rx_kind_e;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_DUMMY = 1'b1
  } seq_state_e;

  function automatic rx_kind_e classify(input logic full,
                                        input logic [BYTE_W-1:0] b);
    if (!full)                  return RX_EMPTY;
    else if (b == CODE_RX_DONE) return RX_DONE;
    else if (b == CODE_DUMMY)   return RX_DUMMY;
    else                        return RX_DATA;
  endfunction

  function automatic logic full_next(input logic full, input logic wr,
                                     input logic rd);
    return wr | (full & ~rd);
  endfunction

  function automatic logic overrun_hit(input logic full, input logic wr,
                                       input logic rd);
    return wr & full & ~rd;
  endfunction

endpackage

// File: rtl/kcs_buffer.sv
module kcs_buffer
  import kcs_mailbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rd,
  input  logic              ovr_clr,
  output logic [BYTE_W-1:0] data,
  output logic              full,
  output logic              ovr,
  output logic              ovr_hit
);

  assign ovr_hit = overrun_hit(full, wr, rd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data <= '0;
      full <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (wr) data <= wdata;
      full <= full_next(full, wr, rd);
      if (ovr_hit)      ovr <= 1'b1;
      else if (ovr_clr) ovr <= 1'b0;
    end
  end

endmodule

// File: rtl/kcs_read_port.sv
module kcs_read_port
  import kcs_mailbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              addr,
  input  logic [BYTE_W-1:0] data_byte,
  input  status_t           status,
  output logic [BYTE_W-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= addr ? BYTE_W'(status) : data_byte;
  end

endmodule

// File: rtl/kcs_signal_seq.sv
module kcs_signal_seq
  import kcs_mailbox_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic out_full,
  output logic busy,
  output logic accept,
  output logic dummy_we
);

  seq_state_e state;

  assign busy     = out_full | (state == SEQ_DUMMY);
  assign accept   = req & ~busy;
  assign dummy_we = (state == SEQ_DUMMY);

  always_ff @(posedge clk) begin
    if (!rst_n)      state <= SEQ_IDLE;
    else if (accept) state <= SEQ_DUMMY;
    else             state <= SEQ_IDLE;
  end

endmodule

// File: rtl/kcs_mailbox.sv
module kcs_mailbox
  import kcs_mailbox_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic        host_addr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic        host_irq,
  output logic [1:0]  host_rx_kind,
  input  logic        bmc_wr,
  input  logic        bmc_rd,
  input  logic        bmc_addr,
  input  logic [7:0]  bmc_wdata,
  output logic [7:0]  bmc_rdata,
  output logic        bmc_irq,
  output logic [1:0]  bmc_rx_kind,
  input  logic        bmc_sig_req,
  input  logic [3:0]  bmc_sig_bits,
  output logic        bmc_sig_busy
);

  // Decoded port events, named for the checker.
  logic host_data_wr, host_stat_wr, host_data_rd;
  logic bmc_data_wr,  bmc_stat_wr,  bmc_data_rd;
  assign host_data_wr = host_wr & ~host_addr;
  assign host_stat_wr = host_wr &  host_addr;
  assign host_data_rd = host_rd & ~host_addr;
  assign bmc_data_wr  = bmc_wr  & ~bmc_addr;
  assign bmc_stat_wr  = bmc_wr  &  bmc_addr;
  assign bmc_data_rd  = bmc_rd  & ~bmc_addr;

  // Signalling helper.
  logic sig_accept, dummy_we;
  logic out_full, in_full, out_ovr, in_ovr;
  logic out_ovr_hit, in_ovr_hit;
  logic [BYTE_W-1:0] out_data, in_data;

  kcs_signal_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (bmc_sig_req),
    .out_full (out_full),
    .busy     (bmc_sig_busy),
    .accept   (sig_accept),
    .dummy_we (dummy_we)
  );

  // Outbound path: helper dummy byte overrides a direct write.
  logic              out_wr_ev, bmc_data_drop;
  logic [BYTE_W-1:0] out_wdata;
  logic              oovr_clr, iovr_clr;
  assign out_wr_ev     = dummy_we | bmc_data_wr;
  assign bmc_data_drop = dummy_we & bmc_data_wr;
  assign out_wdata     = dummy_we ? CODE_DUMMY : bmc_wdata;

  assign oovr_clr = (host_stat_wr & host_wdata[ST_OOVR]) |
                    (bmc_stat_wr  & bmc_wdata[ST_OOVR]);
  assign iovr_clr = (host_stat_wr & host_wdata[ST_IOVR]) |
                    (bmc_stat_wr  & bmc_wdata[ST_IOVR]);

  kcs_buffer u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (out_wr_ev),
    .wdata   (out_wdata),
    .rd      (host_data_rd),
    .ovr_clr (oovr_clr),
    .data    (out_data),
    .full    (out_full),
    .ovr     (out_ovr),
    .ovr_hit (out_ovr_hit)
  );

  kcs_buffer u_in (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (host_data_wr),
    .wdata   (host_wdata),
    .rd      (bmc_data_rd),
    .ovr_clr (iovr_clr),
    .data    (in_data),
    .full    (in_full),
    .ovr     (in_ovr),
    .ovr_hit (in_ovr_hit)
  );

  // Protocol bits: helper write has priority over a direct status write.
  logic [SW_W-1:0] sw_bits;
  always_ff @(posedge clk) begin
    if (!rst_n)           sw_bits <= '0;
    else if (sig_accept)  sw_bits <= bmc_sig_bits;
    else if (bmc_stat_wr) sw_bits <= bmc_wdata[BYTE_W-1 -: SW_W];
  end

  status_t status;
  always_comb begin
    status.sw   = sw_bits;
    status.iovr = in_ovr;
    status.oovr = out_ovr;
    status.ibf  = in_full;
    status.obf  = out_full;
  end

  kcs_read_port u_host_rp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd        (host_rd),
    .addr      (host_addr),
    .data_byte (out_data),
    .status    (status),
    .rdata     (host_rdata)
  );

  kcs_read_port u_bmc_rp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd        (bmc_rd),
    .addr      (bmc_addr),
    .data_byte (in_data),
    .status    (status),
    .rdata     (bmc_rdata)
  );

  assign host_irq     = out_full;
  assign bmc_irq      = in_full;
  assign host_rx_kind = classify(out_full, out_data);
  assign bmc_rx_kind  = classify(in_full, in_data);

endmodule

// File: rtl/kcs_mailbox_chk.sv
module kcs_mailbox_chk
  import kcs_mailbox_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       out_wr_ev,
  input logic       host_data_rd,
  input logic       host_data_wr,
  input logic       bmc_data_rd,
  input logic       host_irq,
  input logic       bmc_irq,
  input logic       bmc_stat_wr,
  input logic       bmc_sig_req,
  input logic       bmc_sig_busy,
  input logic       sig_accept,
  input logic       dummy_we,
  input logic       in_ovr,
  input logic       out_ovr,
  input logic [3:0] sw_bits,
  input logic [1:0] host_rx_kind
);

  assert_obf_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr_ev |=> host_irq);

  assert_obf_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_irq) |-> $past(host_data_rd));

  assert_ibf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    host_data_wr |=> bmc_irq);

  assert_ibf_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bmc_irq) |-> $past(bmc_data_rd));

  assert_status_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_irq && bmc_stat_wr && !out_wr_ev && !sig_accept) |=> !host_irq);

  assert_in_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_data_wr && bmc_irq && !bmc_data_rd) |=> in_ovr);

  assert_out_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr_ev && host_irq && !host_data_rd) |=> out_ovr);

  assert_seq_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sig_accept |=> (dummy_we && bmc_sig_busy));

  assert_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bmc_sig_req && bmc_sig_busy && !bmc_stat_wr) |=> $stable(sw_bits));

  assert_dummy_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_we |=> (host_rx_kind == RX_DUMMY));

endmodule

bind kcs_mailbox kcs_mailbox_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .out_wr_ev    (out_wr_ev),
  .host_data_rd (host_data_rd),
  .host_data_wr (host_data_wr),
  .bmc_data_rd  (bmc_data_rd),
  .host_irq     (host_irq),
  .bmc_irq      (bmc_irq),
  .bmc_stat_wr  (bmc_stat_wr),
  .bmc_sig_req  (bmc_sig_req),
  .bmc_sig_busy (bmc_sig_busy),
  .sig_accept   (sig_accept),
  .dummy_we     (dummy_we),
  .in_ovr       (in_ovr),
  .out_ovr      (out_ovr),
  .sw_bits      (sw_bits),
  .host_rx_kind (host_rx_kind)
);

// File: tb/sim_kcs_mailbox.sv
`timescale 1ns/1ps
module sim_kcs_mailbox;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 0, host_rd = 0, host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic       host_irq;
  logic [1:0] host_rx_kind;
  logic       bmc_wr = 0, bmc_rd = 0, bmc_addr = 0;
  logic [7:0] bmc_wdata = 0;
  logic [7:0] bmc_rdata;
  logic       bmc_irq;
  logic [1:0] bmc_rx_kind;
  logic       bmc_sig_req = 0;
  logic [3:0] bmc_sig_bits = 0;
  logic       bmc_sig_busy;

  kcs_mailbox u0 (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_irq(host_irq), .host_rx_kind(host_rx_kind),
    .bmc_wr(bmc_wr), .bmc_rd(bmc_rd), .bmc_addr(bmc_addr),
    .bmc_wdata(bmc_wdata), .bmc_rdata(bmc_rdata),
    .bmc_irq(bmc_irq), .bmc_rx_kind(bmc_rx_kind),
    .bmc_sig_req(bmc_sig_req), .bmc_sig_bits(bmc_sig_bits),
    .bmc_sig_busy(bmc_sig_busy)
  );

  always #10 clk = ~clk;

  localparam int S_HRD = 0, S_BRD = 1, S_HIRQ = 2, S_BIRQ = 3,
                 S_BUSY = 4, S_HKIND = 5, S_BKIND = 6;

  typedef struct {
    int         due;
    int         sel;
    logic [7:0] val;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] observe(input int sel);
    case (sel)
      S_HRD:   return host_rdata;
      S_BRD:   return bmc_rdata;
      S_HIRQ:  return {7'd0, host_irq};
      S_BIRQ:  return {7'd0, bmc_irq};
      S_BUSY:  return {7'd0, bmc_sig_busy};
      S_HKIND: return {6'd0, host_rx_kind};
      default: return {6'd0, bmc_rx_kind};
    endcase
  endfunction

  // Monitor: compare each queued item in its due cycle.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      logic [7:0] got;
      e = q.pop_front();
      got = observe(e.sel);
      checks++;
      if (got !== e.val) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", e.tag, e.sel, got, e.val);
      end
    end
  end

  task automatic expect_next(input int sel, input logic [7:0] val, input string tag);
    q.push_back('{cyc + 1, sel, val, tag});
  endtask

  task automatic op(input logic hw, input logic ha, input logic [7:0] hd,
                    input logic hr, input logic bw, input logic ba,
                    input logic [7:0] bd, input logic br,
                    input logic sr, input logic [3:0] sb);
    @(negedge clk);
    host_wr = hw; host_addr = ha; host_wdata = hd; host_rd = hr;
    bmc_wr = bw; bmc_addr = ba; bmc_wdata = bd; bmc_rd = br;
    bmc_sig_req = sr; bmc_sig_bits = sb;
  endtask

  task automatic idle();           op(0,0,0,0, 0,0,0,0, 0,0); endtask
  task automatic bmc_write(input logic a, input logic [7:0] d); op(0,0,0,0, 1,a,d,0, 0,0); endtask
  task automatic host_write(input logic a, input logic [7:0] d); op(1,a,d,0, 0,0,0,0, 0,0); endtask
  task automatic host_read(input logic a); op(0,a,0,1, 0,0,0,0, 0,0); endtask
  task automatic bmc_read(input logic a);  op(0,0,0,0, 0,a,0,1, 0,0); endtask
  task automatic signal(input logic [3:0] b); op(0,0,0,0, 0,0,0,0, 1,b); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    idle();
    expect_next(S_HIRQ, 0, "R1"); expect_next(S_BIRQ, 0, "R1");
    expect_next(S_BUSY, 0, "R1"); expect_next(S_HKIND, 0, "R1");
    expect_next(S_BKIND, 0, "R1");
    host_read(1); expect_next(S_HRD, 8'h00, "R1 status");
    bmc_read(0);  expect_next(S_BRD, 8'h00, "R1 data");

    // R2: outbound byte, R8 ordinary data
    bmc_write(0, 8'h5A);
    expect_next(S_HIRQ, 1, "R2"); expect_next(S_HKIND, 1, "R8 data");
    expect_next(S_BUSY, 1, "R6 busy on full");
    host_read(1); expect_next(S_HRD, 8'h01, "R2 obf");
    host_read(0); expect_next(S_HRD, 8'h5A, "R2 byte");
    expect_next(S_HIRQ, 0, "R2 clear"); expect_next(S_HKIND, 0, "R8 empty");
    expect_next(S_BUSY, 0, "R6 busy clear");

    // R3: inbound byte, R8 receive-complete code
    host_write(0, 8'h02);
    expect_next(S_BIRQ, 1, "R3"); expect_next(S_BKIND, 2, "R8 rxdone");
    bmc_read(1); expect_next(S_BRD, 8'h02, "R3 ibf");
    bmc_read(0); expect_next(S_BRD, 8'h02, "R3 byte");
    expect_next(S_BIRQ, 0, "R3 clear");

    // R4: protocol bits, no interrupt, host write ignored
    bmc_write(1, 8'hA0);
    expect_next(S_HIRQ, 0, "R4 no irq"); expect_next(S_BIRQ, 0, "R4 no irq");
    host_read(1); expect_next(S_HRD, 8'hA0, "R4 sw bits");
    host_write(1, 8'h50);
    expect_next(S_BIRQ, 0, "R4 host stat wr");
    host_read(1); expect_next(S_HRD, 8'hA0, "R4 host ignored");

    // R5: inbound overrun and clear
    host_write(0, 8'h11);
    host_write(0, 8'h22);
    bmc_read(1); expect_next(S_BRD, 8'hAA, "R5 in overrun");
    bmc_read(0); expect_next(S_BRD, 8'h22, "R5 overwritten");
    bmc_write(1, 8'hA8);
    bmc_read(1); expect_next(S_BRD, 8'hA0, "R5 in clear");
    // R5: outbound overrun and clear from host
    bmc_write(0, 8'h33);
    bmc_write(0, 8'h44);
    host_read(1); expect_next(S_HRD, 8'hA5, "R5 out overrun");
    host_write(1, 8'h04);
    host_read(1); expect_next(S_HRD, 8'hA1, "R5 out clear");
    host_read(0); expect_next(S_HRD, 8'h44, "R5 overwritten");

    // R6: status update then dummy byte
    signal(4'h3);
    expect_next(S_BUSY, 1, "R6 accept"); expect_next(S_HIRQ, 0, "R6 first step");
    idle();
    expect_next(S_HIRQ, 1, "R6 dummy"); expect_next(S_HKIND, 3, "R8 dummy");
    host_read(1); expect_next(S_HRD, 8'h31, "R6 status");
    host_read(0); expect_next(S_HRD, 8'hFF, "R6 dummy byte");
    expect_next(S_BUSY, 0, "R6 release");

    // R7: refused while outbound full
    bmc_write(0, 8'h66);
    signal(4'h9);
    expect_next(S_BUSY, 1, "R7 busy");
    idle();
    host_read(1); expect_next(S_HRD, 8'h31, "R7 bits kept");
    host_read(0); expect_next(S_HRD, 8'h66, "R7 byte kept");

    // R9: write and read in one cycle
    bmc_write(0, 8'h77);
    op(0,0,0,1, 1,0,8'h88,0, 0,0);
    expect_next(S_HRD, 8'h77, "R9 old byte"); expect_next(S_HIRQ, 1, "R9 still full");
    host_read(1); expect_next(S_HRD, 8'h31, "R9 no overrun");
    host_read(0); expect_next(S_HRD, 8'h88, "R9 new byte");

    // R10: helper wins over direct writes
    op(0,0,0,0, 1,1,8'hC0,0, 1,4'h5);
    op(0,0,0,0, 1,0,8'h12,0, 0,0);
    expect_next(S_HKIND, 3, "R10 dummy wins");
    host_read(1); expect_next(S_HRD, 8'h51, "R10 status wins");
    host_read(0); expect_next(S_HRD, 8'hFF, "R10 byte");

    idle();
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule